// File: doc/BRIEF.md
# Serial Link Request Decoder

This block sits on the link side of a serial bus physical layer and turns a one-wire request line, sampled on every rising system clock edge, into decoded actions. A frame opens with a 1 while the decoder is idle. The three type bits that follow select the frame length: 7 bits for a bus-access request, 9 bits for a register read, and 17 bits for a register write. A 0 stop bit closes every frame. Register writes leave the block as a one-cycle strobe with address and data. Register read addresses wait in a small queue until the status-transfer logic takes them.

Bus-access requests (immediate, isochronous, priority, fair) fill a single pending slot, which the arbiter watches. The slot holds one request at a time. It is emptied by a win or a loss reported by the arbiter, or, for isochronous requests only, by a run of idle cycles after the bus has been seized. A fair or priority request that overlaps the receive state is discarded. Malformed frames raise a one-cycle illegal flag and are otherwise dropped.

The read-address output is a valid/ready stream. `rd_valid` stays high and `rd_addr` stays fixed until a cycle in which `rd_ready` is also high. The consumer raises `rd_ready` only once a status transfer has fully succeeded, so an interrupted transfer is retried against the same head entry. The queue never stalls the serial line. A read that arrives while the queue is full is dropped.

Top module: `link_req_decoder`

## Requirements
- R1: In idle, a sampled 1 on `req_in` starts a frame. Bits 1..3 form the type code, first bit most significant. Type 100 (read) gives a 9-bit frame, type 101 (write) gives a 17-bit frame, and every other code gives a 7-bit frame. The last bit is the stop bit. A new start bit is accepted on the clock edge right after the stop bit.
- R2: In a write frame, bits 4..7 are the address and bits 8..15 are the data, each field sent most significant bit first. `wr_strobe` is high for exactly the one cycle after the edge that samples the stop bit, with `wr_addr`/`wr_data` valid in that cycle.
- R3: In a read frame, bits 4..7 are the address. It enters a queue of `RDQ_DEPTH` entries one edge after the stop bit is sampled. The queue emits entries in arrival order on `rd_valid`/`rd_addr`, holding each one until it is accepted with `rd_ready`. A read arriving while the queue is full is dropped.
- R4: Type codes 000, 001, 010 and 011 are bus-access requests: immediate, isochronous, priority and fair. Bits 4..5 are the speed code (00, 01, 10, 11). An accepted request shows `pend_valid`=1 from the second edge after the stop bit. `pend_type` equals the low two type bits and `pend_speed` equals the speed code.
- R5: While `pend_valid` is 1, a newly decoded bus-access request is ignored, and the pending type and speed do not change.
- R6: Register reads and writes are decoded and acted on regardless of `pend_valid`.
- R7: A clock edge with `bus_won`=1 empties the pending slot, whatever the request type.
- R8: A clock edge with `bus_lost`=1 empties the slot when it holds an immediate, priority or fair request. An isochronous request stays.
- R9: A fair or priority request is discarded if `rx_active` was 1 on any edge from its start bit through its stop bit. Immediate and isochronous requests are unaffected by `rx_active`.
- R10: A pending isochronous request is removed on the `ISO_IDLE_CYCLES`-th consecutive edge with `seized_idle`=1. It is still present after one edge fewer.
- R11: A frame whose stop bit is 1, or whose type code is 110 or 111, produces a one-cycle `illegal_req` pulse in the cycle after its stop bit. Such a frame writes nothing, queues nothing and fills no pending slot.
- R12: After reset, `pend_valid`, `wr_strobe`, `rd_valid` and `illegal_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 1 | Serial request line |
| rx_active | input | 1 | Interface is in the receive state |
| bus_won | input | 1 | Arbiter reports the pending request won |
| bus_lost | input | 1 | Arbiter reports an incoming packet (request lost) |
| seized_idle | input | 1 | Bus seized and interface idle this cycle |
| pend_valid | output | 1 | A bus-access request is pending |
| pend_type | output | 2 | Pending kind: 00 imm, 01 iso, 10 pri, 11 fair |
| pend_speed | output | 2 | Pending speed code |
| wr_strobe | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_valid | output | 1 | Read address available |
| rd_ready | input | 1 | Consumer accepts the read address |
| rd_addr | output | 4 | Register read address at queue head |
| illegal_req | output | 1 | One-cycle malformed-frame pulse |

## Verification
The assertions check the following on every cycle:
- the decode pulses are mutually exclusive, and the write and illegal pulses last a single cycle;
- the read stream holds its address under back-pressure;
- the pending slot keeps its contents unless a win, a qualifying loss or the isochronous timeout occurs;
- a win always empties the slot, and a loss never removes an isochronous request.

Only the bench scenarios can show the rest: correct field extraction from MSB-first frames, frames sent back to back, the exact edge on which the isochronous timeout fires, discard of fair requests overlapping the receive state, and dropping of reads into a full queue.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
  typedef enum logic [2:0] {
    RC_IMM   = 3'b000,
    RC_ISO   = 3'b001,
    RC_PRI   = 3'b010,
    RC_FAIR  = 3'b011,
    RC_READ  = 3'b100,
    RC_WRITE = 3'b101
  } req_code_e;

  localparam int TYPE_BITS  = 3;
  localparam int SPEED_BITS = 2;

  typedef enum logic [1:0] {
    BK_IMM  = 2'b00,
    BK_ISO  = 2'b01,
    BK_PRI  = 2'b10,
    BK_FAIR = 2'b11
  } bus_kind_e;
endpackage

// File: rtl/lreq_deframer.sv
module lreq_deframer #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              rx_active,
  output logic              wr_pulse,
  output logic              rd_pulse,
  output logic              bus_pulse,
  output logic              illegal_pulse,
  output logic [1:0]        f_kind,
  output logic [1:0]        f_speed,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_data,
  output logic              f_rx_hit
);
  import lreq_pkg::*;

  localparam int BUS_LAST   = 1 + TYPE_BITS + SPEED_BITS;
  localparam int READ_LAST  = 1 + TYPE_BITS + ADDR_W;
  localparam int WRITE_LAST = READ_LAST + DATA_W;
  localparam int SR_W       = WRITE_LAST - 1;
  localparam int CNT_W      = $clog2(WRITE_LAST + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [SR_W-1:0]  sr;
  logic [2:0]       code_q;
  logic             rx_hit;
  logic [CNT_W-1:0] last_idx;
  logic             at_stop;

  always_comb begin
    case (code_q)
      RC_READ:  last_idx = CNT_W'(READ_LAST);
      RC_WRITE: last_idx = CNT_W'(WRITE_LAST);
      default:  last_idx = CNT_W'(BUS_LAST);
    endcase
  end

  assign at_stop = busy && (cnt > CNT_W'(TYPE_BITS)) && (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; sr <= '0; code_q <= '0; rx_hit <= 1'b0;
      wr_pulse <= 1'b0; rd_pulse <= 1'b0; bus_pulse <= 1'b0; illegal_pulse <= 1'b0;
      f_kind <= '0; f_speed <= '0; f_addr <= '0; f_data <= '0; f_rx_hit <= 1'b0;
    end else begin
      wr_pulse <= 1'b0; rd_pulse <= 1'b0; bus_pulse <= 1'b0; illegal_pulse <= 1'b0;
      if (!busy) begin
        if (req_in) begin
          busy   <= 1'b1;
          cnt    <= CNT_W'(1);
          sr     <= '0;
          rx_hit <= rx_active;
        end
      end else if (at_stop) begin
        busy     <= 1'b0;
        f_rx_hit <= rx_hit | rx_active;
        if (req_in || code_q[2:1] == 2'b11) begin
          illegal_pulse <= 1'b1;
        end else begin
          case (code_q)
            RC_READ: begin
              rd_pulse <= 1'b1;
              f_addr   <= sr[ADDR_W-1:0];
            end
            RC_WRITE: begin
              wr_pulse <= 1'b1;
              f_addr   <= sr[DATA_W +: ADDR_W];
              f_data   <= sr[DATA_W-1:0];
            end
            default: begin
              bus_pulse <= 1'b1;
              f_kind    <= code_q[1:0];
              f_speed   <= sr[SPEED_BITS-1:0];
            end
          endcase
        end
      end else begin
        rx_hit <= rx_hit | rx_active;
        sr     <= {sr[SR_W-2:0], req_in};
        cnt    <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(TYPE_BITS)) code_q <= {sr[1:0], req_in};
      end
    end
  end

  assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pulse, rd_pulse, bus_pulse, illegal_pulse}));
  assert_write_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  assert_illegal_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |=> !illegal_pulse);
endmodule

// File: rtl/lreq_rdq.sv
module lreq_rdq #(
  parameter int DEPTH = 4,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign do_pop    = out_valid && out_ready;
  assign do_push   = push && (count != CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (do_push && wp == PTR_W'(g)) mem[g] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_hold_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/lreq_pending.sv
module lreq_pending #(
  parameter int ISO_IDLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] kind,
  input  logic [1:0] speed,
  input  logic       rx_hit,
  input  logic       bus_won,
  input  logic       bus_lost,
  input  logic       seized_idle,
  output logic       pend_valid,
  output logic [1:0] pend_type,
  output logic [1:0] pend_speed
);
  import lreq_pkg::*;

  localparam int TMO_W = $clog2(ISO_IDLE_CYCLES + 1);

  logic [TMO_W-1:0] tcnt;
  logic             is_iso, tmo_hit, drop_rx, accept, clear;

  assign is_iso  = (pend_type == BK_ISO);
  assign tmo_hit = pend_valid && is_iso && seized_idle && (tcnt == TMO_W'(ISO_IDLE_CYCLES - 1));
  assign drop_rx = rx_hit && (kind == BK_PRI || kind == BK_FAIR);
  assign accept  = load && !pend_valid && !drop_rx;
  assign clear   = pend_valid && (bus_won || (bus_lost && !is_iso) || tmo_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0; pend_type <= '0; pend_speed <= '0; tcnt <= '0;
    end else begin
      if (clear) begin
        pend_valid <= 1'b0;
      end else if (accept) begin
        pend_valid <= 1'b1;
        pend_type  <= kind;
        pend_speed <= speed;
      end
      if (pend_valid && is_iso && seized_idle && !tmo_hit) tcnt <= tcnt + TMO_W'(1);
      else tcnt <= '0;
    end
  end

  assert_slot_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && !bus_won && !(bus_lost && !is_iso) && !tmo_hit
      |=> pend_valid && $stable(pend_type) && $stable(pend_speed));
  assert_won_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_won |=> !pend_valid);
  assert_lost_keeps_iso_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && is_iso && bus_lost && !bus_won && !tmo_hit |=> pend_valid);
endmodule

// File: rtl/link_req_decoder.sv
module link_req_decoder #(
  parameter int ADDR_W          = 4,
  parameter int DATA_W          = 8,
  parameter int RDQ_DEPTH       = 4,
  parameter int ISO_IDLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              rx_active,
  input  logic              bus_won,
  input  logic              bus_lost,
  input  logic              seized_idle,
  output logic              pend_valid,
  output logic [1:0]        pend_type,
  output logic [1:0]        pend_speed,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              illegal_req
);
  logic              rd_pulse, bus_pulse, rx_hit;
  logic [1:0]        kind, speed;
  logic [ADDR_W-1:0] f_addr;

  lreq_deframer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deframer (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .rx_active(rx_active),
    .wr_pulse(wr_strobe), .rd_pulse(rd_pulse), .bus_pulse(bus_pulse),
    .illegal_pulse(illegal_req), .f_kind(kind), .f_speed(speed),
    .f_addr(f_addr), .f_data(wr_data), .f_rx_hit(rx_hit)
  );

  assign wr_addr = f_addr;

  lreq_rdq #(.DEPTH(RDQ_DEPTH), .W(ADDR_W)) u_rdq (
    .clk(clk), .rst_n(rst_n), .push(rd_pulse), .push_data(f_addr),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_addr)
  );

  lreq_pending #(.ISO_IDLE_CYCLES(ISO_IDLE_CYCLES)) u_pending (
    .clk(clk), .rst_n(rst_n), .load(bus_pulse), .kind(kind), .speed(speed),
    .rx_hit(rx_hit), .bus_won(bus_won), .bus_lost(bus_lost),
    .seized_idle(seized_idle), .pend_valid(pend_valid),
    .pend_type(pend_type), .pend_speed(pend_speed)
  );
endmodule

// File: tb/test_link_req_decoder.sv
`timescale 1ns/1ps
module test_link_req_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_in = 1'b0, rx_active = 1'b0, bus_won = 1'b0, bus_lost = 1'b0;
  logic seized_idle = 1'b0, rd_ready = 1'b1;
  logic pend_valid, wr_strobe, rd_valid, illegal_req;
  logic [1:0] pend_type, pend_speed;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct packed { logic [1:0] kind; logic [3:0] a; logic [7:0] d; } ev_t;
  ev_t exp_q[$];

  always #10 clk = ~clk;

  link_req_decoder i_link_req_decoder (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .rx_active(rx_active),
    .bus_won(bus_won), .bus_lost(bus_lost), .seized_idle(seized_idle),
    .pend_valid(pend_valid), .pend_type(pend_type), .pend_speed(pend_speed),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .illegal_req(illegal_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [3:0] a, input logic [7:0] d);
    exp_q.push_back('{kind: k, a: a, d: d});
  endtask

  // Monitor: kind 0 write (R2), 1 read (R3), 2 illegal (R11)
  task automatic got_ev(input logic [1:0] k, input logic [3:0] a, input logic [7:0] d);
    ev_t e;
    string tag;
    tag = (k == 0) ? "R2 write event" : (k == 1) ? "R3 read event" : "R11 illegal event";
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL %s unexpected actual=%0d/%0d expected=none", tag, a, d);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.a != a || e.d != d) begin
        failures++;
        $display("FAIL %s actual=k%0d a%0d d%0d expected=k%0d a%0d d%0d",
                 tag, k, a, d, e.kind, e.a, e.d);
      end
    end
  endtask

  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      if (wr_strobe) got_ev(2'd0, wr_addr, wr_data);
      if (rd_valid && rd_ready) got_ev(2'd1, rd_addr, 8'd0);
      if (illegal_req) got_ev(2'd2, 4'd0, 8'd0);
    end
  end

  // Sends n bits of v, most significant first, then one idle cycle.
  task automatic send_bits(input logic [31:0] v, input int n, input int rx_at = -1);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      req_in = v[i];
      rx_active = ((n - 1 - i) == rx_at);
    end
    @(negedge clk);
    req_in = 1'b0;
    rx_active = 1'b0;
  endtask

  task automatic send_wr(input logic [3:0] a, input logic [7:0] d);
    send_bits({15'd0, 1'b1, 3'b101, a, d, 1'b0}, 17);
  endtask
  task automatic send_rd(input logic [3:0] a);
    send_bits({23'd0, 1'b1, 3'b100, a, 1'b0}, 9);
  endtask
  task automatic send_bus(input logic [2:0] c, input logic [1:0] s, input int rx_at = -1);
    send_bits({25'd0, 1'b1, c, s, 1'b0}, 7, rx_at);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pend_valid", pend_valid, 0);
    chk("R12 wr_strobe", wr_strobe, 0);
    chk("R12 rd_valid", rd_valid, 0);
    chk("R12 illegal_req", illegal_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 write decode
    expect_ev(0, 4'h5, 8'hA5);
    send_wr(4'h5, 8'hA5);
    settle();
    // R3 read decode
    expect_ev(1, 4'h9, 8'h00);
    send_rd(4'h9);
    settle();

    // R4 fair request, speed 01
    send_bus(3'b011, 2'b01);
    @(negedge clk);
    chk("R4 pend_valid", pend_valid, 1);
    chk("R4 pend_type", pend_type, 3);
    chk("R4 pend_speed", pend_speed, 1);
    // R5 new bus request ignored while pending
    send_bus(3'b010, 2'b10);
    settle();
    chk("R5 pend_type kept", pend_type, 3);
    chk("R5 pend_speed kept", pend_speed, 1);
    // R6 register access while pending
    expect_ev(0, 4'hC, 8'h3E);
    send_wr(4'hC, 8'h3E);
    expect_ev(1, 4'h2, 8'h00);
    send_rd(4'h2);
    settle();
    chk("R6 pending survives", pend_valid, 1);
    // R8 loss clears fair
    pulse(bus_lost);
    chk("R8 fair lost", pend_valid, 0);

    // R9 fair overlapping receive state is discarded
    send_bus(3'b011, 2'b00, 3);
    settle();
    chk("R9 fair discarded", pend_valid, 0);
    // R9 immediate not affected by receive state, speed 10
    send_bus(3'b000, 2'b10, 2);
    @(negedge clk);
    chk("R9 imm kept", pend_valid, 1);
    chk("R4 imm speed", pend_speed, 2);
    pulse(bus_lost);
    chk("R8 imm lost", pend_valid, 0);

    // R8/R10 isochronous
    send_bus(3'b001, 2'b01);
    @(negedge clk);
    chk("R4 iso type", pend_type, 1);
    pulse(bus_lost);
    chk("R8 iso survives loss", pend_valid, 1);
    @(negedge clk); seized_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 iso before timeout", pend_valid, 1);
    @(negedge clk);
    chk("R10 iso timeout", pend_valid, 0);
    seized_idle = 1'b0;
    // R7 win clears iso
    send_bus(3'b001, 2'b00);
    @(negedge clk);
    chk("R7 iso pending", pend_valid, 1);
    pulse(bus_won);
    chk("R7 won clears", pend_valid, 0);

    // R11 reserved type and bad stop bit
    expect_ev(2, 4'h0, 8'h00);
    send_bits({25'd0, 1'b1, 3'b110, 2'b01, 1'b0}, 7);
    settle();
    chk("R11 reserved no pending", pend_valid, 0);
    expect_ev(2, 4'h0, 8'h00);
    send_bits({15'd0, 1'b1, 3'b101, 4'h7, 8'h11, 1'b1}, 17);
    settle();

    // R1 back-to-back frames: write then read with no idle gap
    expect_ev(0, 4'hF, 8'h81);
    expect_ev(1, 4'h6, 8'h00);
    send_bits({6'd0, 1'b1, 3'b101, 4'hF, 8'h81, 1'b0, 1'b1, 3'b100, 4'h6, 1'b0}, 26);
    settle();

    // R3 back-pressure and full-queue drop
    @(negedge clk); rd_ready = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      send_rd(4'(k));
      if (k <= 4) expect_ev(1, 4'(k), 8'h00);
    end
    settle();
    chk("R3 held valid", rd_valid, 1);
    chk("R3 held head", rd_addr, 1);
    rd_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 queue drained", rd_valid, 0);
    chk("R3 scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule